// File: doc/BRIEF.md
# Reconfigurable Fixed-Width Multiplier

This block multiplies two unsigned 16-bit operands and always returns a 16-bit result. A 2-bit mode input decides how the result relates to the operands. In byte mode the low bytes of both operands are multiplied and the whole 16-bit product comes out exactly. In the two wide modes, the block returns only the most significant 16 bits of the product. Those modes are 16x8, which uses the low byte of b, and 16x16. The lower columns are dropped with no rounding and no error compensation.

Inside, the operands are split into 8-bit blocks and four 8x8 sub-multipliers work in parallel. Their products are shifted to their column weights and added, and the mode removes any sub-product it does not need. A window selector then picks the 16 result bits from the sum. The result and its valid flag are registered, so a request presented with `valid_i` shows up one clock later.

Top module: `mfw_mul`

## Requirements
- R1: While `rst_ni` is low, `product_o` is 0 and `valid_o` is 0.
- R2: `valid_o` is high in the cycle after a clock edge at which `valid_i` was high, and low after an edge at which `valid_i` was low.
- R3: `product_o` is loaded only at an edge where `valid_i` is high, and otherwise it keeps its value even when the operands or the mode change.
- R4: With mode 2'b00 the result is the exact product `a_i[7:0] * b_i[7:0]`, and the high bytes of both operands have no effect.
- R5: With mode 2'b01 the result is bits [23:8] of `a_i * b_i[7:0]`, and `b_i[15:8]` has no effect.
- R6: With mode 2'b10 the result is bits [31:16] of the 32-bit product `a_i * b_i`.
- R7: Mode 2'b11 gives the same result as mode 2'b10 for the same operands.
- R8: In the truncated modes, the discarded low columns never round the result up. For example, 16'hFFFF * 16'hFFFF in mode 2'b10 gives 16'hFFFE, and 16'h0001 * 16'hFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; the operands and the mode are captured on this edge |
| mode_i | input | 2 | 00 = 8x8 exact, 01 = 16x8 truncated, 10 or 11 = 16x16 truncated |
| a_i | input | 16 | Operand a, unsigned |
| b_i | input | 16 | Operand b, unsigned |
| product_o | output | 16 | Registered 16-bit result |
| valid_o | output | 1 | High for one cycle after each captured request |

## Verification
The hardest case to reach from the ports is a truncated result whose discarded low columns are large, because that is where a hidden rounding carry or a misaligned sub-product would change the kept bits. Random operands seldom reach that boundary. The stimulus therefore uses directed all-ones and one-times-all-ones operands in each truncated mode, and it places nonzero values in the bytes each mode must ignore. Hold behaviour is checked by changing the operands and the mode while `valid_i` is low and then watching that the output does not move.

// File: rtl/mfw_pkg.sv
package mfw_pkg;
  typedef enum logic [1:0] {
    MODE_8X8   = 2'b00,
    MODE_16X8  = 2'b01,
    MODE_16X16 = 2'b10,
    MODE_ALT   = 2'b11
  } mfw_mode_e;
endpackage

// File: rtl/mfw_blk_mul.sv
module mfw_blk_mul #(
  parameter int BLK_W = 8
) (
  input  logic [BLK_W-1:0]   x_i,
  input  logic [BLK_W-1:0]   y_i,
  output logic [2*BLK_W-1:0] p_o
);
  assign p_o = {{BLK_W{1'b0}}, x_i} * {{BLK_W{1'b0}}, y_i};
endmodule

// File: rtl/mfw_accum.sv
module mfw_accum
  import mfw_pkg::*;
#(
  parameter int BLK_W = 8,
  localparam int PROD_W = 2 * BLK_W,
  localparam int ACC_W  = 4 * BLK_W
) (
  input  mfw_mode_e           mode_i,
  input  logic [4*PROD_W-1:0] sub_i,   // sub-product k: a block k[0], b block k[1]
  output logic [ACC_W-1:0]    sum_o
);
  logic [3:0] en;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      unique case (mode_i)
        MODE_8X8:  en[k] = (k == 0);
        MODE_16X8: en[k] = ((k >> 1) == 0);
        default:   en[k] = 1'b1;
      endcase
    end
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < 4; k++) begin
      if (en[k])
        sum_o = sum_o + (ACC_W'(sub_i[k*PROD_W +: PROD_W]) << (((k & 1) + (k >> 1)) * BLK_W));
    end
  end
endmodule

// File: rtl/mfw_window.sv
module mfw_window
  import mfw_pkg::*;
#(
  parameter int BLK_W = 8,
  localparam int OUT_W = 2 * BLK_W,
  localparam int ACC_W = 4 * BLK_W
) (
  input  mfw_mode_e        mode_i,
  input  logic [ACC_W-1:0] sum_i,
  output logic [OUT_W-1:0] res_o
);
  always_comb begin
    unique case (mode_i)
      MODE_8X8:  res_o = sum_i[OUT_W-1:0];
      MODE_16X8: res_o = sum_i[3*BLK_W-1:BLK_W];
      default:   res_o = sum_i[ACC_W-1:OUT_W];
    endcase
  end
endmodule

// File: rtl/mfw_mul.sv
module mfw_mul
  import mfw_pkg::*;
#(
  parameter int BLK_W = 8,
  localparam int OP_W   = 2 * BLK_W,
  localparam int PROD_W = 2 * BLK_W,
  localparam int ACC_W  = 4 * BLK_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      mode_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [OP_W-1:0] product_o,
  output logic            valid_o
);
  mfw_mode_e           mode;
  logic [4*PROD_W-1:0] sub;
  logic [ACC_W-1:0]    sum;
  logic [OP_W-1:0]     res;

  assign mode = mfw_mode_e'(mode_i);

  for (genvar k = 0; k < 4; k++) begin : g_blk
    mfw_blk_mul #(.BLK_W(BLK_W)) i_blk (
      .x_i(a_i[(k & 1)*BLK_W +: BLK_W]),
      .y_i(b_i[(k >> 1)*BLK_W +: BLK_W]),
      .p_o(sub[k*PROD_W +: PROD_W])
    );
  end

  mfw_accum #(.BLK_W(BLK_W)) i_accum (
    .mode_i(mode),
    .sub_i (sub),
    .sum_o (sum)
  );

  mfw_window #(.BLK_W(BLK_W)) i_window (
    .mode_i(mode),
    .sum_i (sum),
    .res_o (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      product_o <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) product_o <= res;
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(product_o));
  assert_byte_mode_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_8X8) |-> (sum[ACC_W-1:PROD_W] == '0));
  assert_byte_mode_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode == MODE_8X8) |=>
      (product_o == $past({{BLK_W{1'b0}}, a_i[BLK_W-1:0]} * {{BLK_W{1'b0}}, b_i[BLK_W-1:0]})));
  assert_half_mode_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_16X8) |-> (sum[ACC_W-1:3*BLK_W] == '0));
endmodule

// File: tb/test_mfw_mul.sv
`timescale 1ns/1ps
module test_mfw_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [15:0] prod;
  logic        vout;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mfw_mul i_mfw_mul (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode),
    .a_i(a), .b_i(b), .product_o(prod), .valid_o(vout)
  );

  function automatic logic [15:0] ref_res(logic [1:0] m, logic [15:0] x, logic [15:0] y);
    logic [31:0] full;
    case (m)
      2'b00: begin full = {24'b0, x[7:0]} * {24'b0, y[7:0]}; return full[15:0]; end
      2'b01: begin full = {16'b0, x} * {24'b0, y[7:0]}; return full[23:8]; end
      default: begin full = {16'b0, x} * {16'b0, y}; return full[31:16]; end
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one request at a negedge, check the registered result one edge later
  task automatic op(string req, logic [1:0] m, logic [15:0] x, logic [15:0] y, logic [15:0] exp);
    @(negedge clk);
    mode = m; a = x; b = y; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(req, prod, exp);
    chk("R2", {15'b0, vout}, 16'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    valid = 1'b1; a = 16'hFFFF; b = 16'hFFFF; mode = 2'b10;
    repeat (3) @(negedge clk);
    chk("R1 product", prod, 16'h0);
    chk("R1 valid", {15'b0, vout}, 16'h0);
    valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_byte_mode();
    op("R4 zero", 2'b00, 16'hAB00, 16'hCD00, 16'h0000);
    op("R4 one", 2'b00, 16'h1201, 16'h3401, 16'h0001);
    op("R4 ones", 2'b00, 16'hFFFF, 16'hFFFF, 16'hFE01);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] x = 16'($urandom);
      logic [15:0] y = 16'($urandom);
      op("R4 random", 2'b00, x, y, ref_res(2'b00, x, y));
    end
  endtask

  task automatic t_half_mode();
    op("R5 zero", 2'b01, 16'h0000, 16'hFF00, 16'h0000);
    op("R5 ones", 2'b01, 16'hFFFF, 16'hAAFF, 16'hFEFF);
    op("R5 one", 2'b01, 16'hFFFF, 16'h5501, 16'h00FF);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] x = 16'($urandom);
      logic [15:0] y = 16'($urandom);
      op("R5 random", 2'b01, x, y, ref_res(2'b01, x, y));
    end
  endtask

  task automatic t_full_mode();
    op("R6 R8 ones", 2'b10, 16'hFFFF, 16'hFFFF, 16'hFFFE);
    op("R8 one x ones", 2'b10, 16'h0001, 16'hFFFF, 16'h0000);
    op("R6 zero", 2'b10, 16'h0000, 16'hFFFF, 16'h0000);
    op("R6 mid", 2'b10, 16'h8000, 16'h0002, 16'h0001);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] x = 16'($urandom);
      logic [15:0] y = 16'($urandom);
      op("R6 random", 2'b10, x, y, ref_res(2'b10, x, y));
    end
  endtask

  task automatic t_alt_mode();
    op("R7 ones", 2'b11, 16'hFFFF, 16'hFFFF, 16'hFFFE);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] x = 16'($urandom);
      logic [15:0] y = 16'($urandom);
      op("R7 random", 2'b11, x, y, ref_res(2'b10, x, y));
    end
  endtask

  task automatic t_hold();
    op("R3 load", 2'b10, 16'h1234, 16'h5678, ref_res(2'b10, 16'h1234, 16'h5678));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      mode = 2'(i); a = 16'($urandom); b = 16'($urandom);
      chk("R3 held", prod, ref_res(2'b10, 16'h1234, 16'h5678));
      chk("R2 idle", {15'b0, vout}, 16'h0);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_byte_mode();
    t_half_mode();
    t_full_mode();
    t_alt_mode();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule